// File: doc/BRIEF.md
# Fused Compare-and-Branch Resolver

This block decides, within a single decode cycle, whether a control-transfer instruction of a 32-bit integer RISC-V core redirects fetch, and where to. It receives the two source-register values, the address of the instruction being resolved, an immediate that has already been assembled and sign-extended, and a four-bit transfer kind. It returns a taken bit, the next fetch address and the value a jump writes to its destination register.

The six conditional compares act directly on the register values. No flag register and no temporary register sit between the compare and the decision. A single shared subtractor (or, by parameter, plain comparators) yields equality, signed less-than and unsigned less-than. The two "greater or equal" kinds are the exact complements of the two "less than" kinds. The block holds no state: the outputs follow the current inputs in the same cycle. The caller must present operands that are valid in that same cycle, with forwarding already applied. Fetch redirection and pipeline flushing belong to the surrounding pipeline.

Top module: `bru_unit`

## Requirements
- R1: Kind codes are 0 none, 1 equal, 2 not-equal, 3 signed less, 4 signed greater-or-equal, 5 unsigned less, 6 unsigned greater-or-equal, 7 direct jump, 8 register jump. Code 0 and codes 9 to 15 give taken 0, link 0 and a next address of pc+4.
- R2: Kind 1 is taken exactly when rs1 equals rs2. Kind 2 is taken exactly when they differ.
- R3: Kind 3 is taken when rs1 is less than rs2 with both read as two's-complement values. Kind 4 is taken when rs1 is greater than or equal to rs2, read the same way.
- R4: Kind 5 is taken when rs1 is less than rs2 with both read as unsigned values. Kind 6 is taken when rs1 is greater than or equal to rs2, read the same way.
- R5: For any operand pair, kind 4 gives the inverse of kind 3, and kind 6 gives the inverse of kind 5.
- R6: A taken conditional branch gives next address pc + imm, with bit 0 of imm treated as 0 (2-byte granularity). A branch that is not taken gives pc+4. Conditional branches give link 0.
- R7: Kind 7 is always taken. It gives next address pc + imm, with bit 0 of imm treated as 0, and link pc+4.
- R8: Kind 8 is always taken. It gives next address rs1 + imm with bit 0 of the sum forced to 0, and link pc+4.
- R9: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.
- R10: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| kind_i | input | 4 | Transfer kind code (see R1) |
| rs1_i | input | 32 | First source register value, already forwarded |
| rs2_i | input | 32 | Second source register value, already forwarded |
| pc_i | input | 32 | Address of the instruction being resolved |
| imm_i | input | 32 | Sign-extended, assembled immediate |
| taken_o | output | 1 | Control transfer happens |
| target_o | output | 32 | Next fetch address |
| link_o | output | 32 | Value a jump writes to its destination register |

## Verification
The block has no storage, so any fault appears on the ports in the same cycle as the stimulus that exposes it. A wrong compare shows up as a taken bit that disagrees with the operand relation. A wrong adder input or a missing bit-0 clear shows up as a wrong next address. Each case changes one operand relation or one address bit on purpose: equal operands, a signed/unsigned disagreement, the most negative value, odd immediates and sums, and pc wraparound.

// File: rtl/bru_pkg.sv
// Package: shared kind encoding and compare-result type for the
// compare-and-branch resolver. Assumes a 4-bit kind field.
package bru_pkg;

    typedef enum logic [3:0] {
        CT_NONE = 4'd0,
        CT_EQ   = 4'd1,
        CT_NE   = 4'd2,
        CT_LT   = 4'd3,
        CT_GE   = 4'd4,
        CT_LTU  = 4'd5,
        CT_GEU  = 4'd6,
        CT_JAL  = 4'd7,
        CT_JALR = 4'd8
    } ctl_kind_e;

    // Raw relations between the two operands; consumed at once, never stored.
    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_res_t;

endpackage

// File: rtl/bru_compare.sv
// bru_compare: derives equality, signed-less and unsigned-less relations
// of two operands. USE_SUB selects one shared subtractor or direct
// comparators. Assumes W >= 2. Purely combinational.
module bru_compare
    import bru_pkg::*;
#(
    parameter int W       = 32,
    parameter bit USE_SUB = 1'b1
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output cmp_res_t     res
);

    localparam int MSB = W - 1;

    logic ltu_w;
    logic eq_w;

    generate
        if (USE_SUB) begin : g_sub
            logic [W:0] diff;
            // Shared subtractor: the borrow out gives the unsigned less-than.
            always_comb begin
                diff  = {1'b0, op_a} - {1'b0, op_b};
                ltu_w = diff[W];
                eq_w  = (diff[W-1:0] == '0);
            end
        end else begin : g_cmp
            // Direct comparators, traded for a shorter carry path.
            always_comb begin
                ltu_w = (op_a < op_b);
                eq_w  = (op_a == op_b);
            end
        end
    endgenerate

    // Signed view: differing signs decide alone, else the unsigned view holds.
    always_comb begin
        res.eq   = eq_w;
        res.lt_u = ltu_w;
        res.lt_s = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : ltu_w;
    end

endmodule

// File: rtl/bru_decide.sv
// bru_decide: turns the kind code and the operand relations into the
// taken decision and the jump qualifiers. Undefined codes are treated as
// "no transfer". Purely combinational.
module bru_decide
    import bru_pkg::*;
(
    input  logic [3:0] kind,
    input  cmp_res_t   res,
    output logic       taken,
    output logic       is_jump,
    output logic       is_reg_jump
);

    ctl_kind_e k;

    // Kind decode: the relation feeds the decision directly.
    always_comb begin
        k           = ctl_kind_e'(kind);
        taken       = 1'b0;
        is_jump     = 1'b0;
        is_reg_jump = 1'b0;
        case (k)
            CT_EQ:   taken = res.eq;
            CT_NE:   taken = ~res.eq;
            CT_LT:   taken = res.lt_s;
            CT_GE:   taken = ~res.lt_s;
            CT_LTU:  taken = res.lt_u;
            CT_GEU:  taken = ~res.lt_u;
            CT_JAL: begin
                taken   = 1'b1;
                is_jump = 1'b1;
            end
            CT_JALR: begin
                taken       = 1'b1;
                is_jump     = 1'b1;
                is_reg_jump = 1'b1;
            end
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
// bru_target: forms the sequential address and the transfer destination,
// then selects the next fetch address. Pc-relative offsets lose bit 0;
// register jumps clear bit 0 of the sum. Wraps modulo 2^W.
module bru_target #(
    parameter int W          = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] base_reg,
    input  logic [W-1:0] imm,
    input  logic         reg_jump,
    input  logic         taken,
    output logic [W-1:0] seq_pc,
    output logic [W-1:0] next_pc
);

    localparam logic [W-1:0] STEP = W'(INSN_BYTES);

    logic [W-1:0] base;
    logic [W-1:0] offs;
    logic [W-1:0] sum;
    logic [W-1:0] dest;

    // Single destination adder shared by pc-relative and register jumps.
    always_comb begin
        base = reg_jump ? base_reg : pc;
        offs = reg_jump ? imm : {imm[W-1:1], 1'b0};
        sum  = base + offs;
        dest = reg_jump ? {sum[W-1:1], 1'b0} : sum;
    end

    // Fall-through address and final selection.
    always_comb begin
        seq_pc  = pc + STEP;
        next_pc = taken ? dest : seq_pc;
    end

endmodule

// File: rtl/bru_unit.sv
// bru_unit: top of the compare-and-branch resolver. Resolves a control
// transfer in the cycle its operands arrive. Assumes the caller has
// already forwarded the operands and assembled the immediate.
module bru_unit #(
    parameter int W          = 32,
    parameter int INSN_BYTES = 4,
    parameter bit USE_SUB    = 1'b1
) (
    input  logic [3:0]   kind_i,
    input  logic [W-1:0] rs1_i,
    input  logic [W-1:0] rs2_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] imm_i,
    output logic         taken_o,
    output logic [W-1:0] target_o,
    output logic [W-1:0] link_o
);

    bru_pkg::cmp_res_t rel;
    logic              jump_w;
    logic              reg_jump_w;
    logic [W-1:0]      seq_w;

    bru_compare #(.W(W), .USE_SUB(USE_SUB)) u_cmp (
        .op_a (rs1_i),
        .op_b (rs2_i),
        .res  (rel)
    );

    bru_decide u_dec (
        .kind        (kind_i),
        .res         (rel),
        .taken       (taken_o),
        .is_jump     (jump_w),
        .is_reg_jump (reg_jump_w)
    );

    bru_target #(.W(W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc       (pc_i),
        .base_reg (rs1_i),
        .imm      (imm_i),
        .reg_jump (reg_jump_w),
        .taken    (taken_o),
        .seq_pc   (seq_w),
        .next_pc  (target_o)
    );

    // Link value is only meaningful for jumps.
    always_comb begin
        link_o = jump_w ? seq_w : '0;
    end

endmodule

// File: rtl/bru_unit_chk.sv
// bru_unit_chk: port-level invariants of the resolver, bound to bru_unit.
// Immediate checks, since the block has no clock.
module bru_unit_chk #(
    parameter int W = 32
) (
    input logic [3:0]   kind_i,
    input logic [W-1:0] rs1_i,
    input logic [W-1:0] rs2_i,
    input logic [W-1:0] pc_i,
    input logic [W-1:0] imm_i,
    input logic         taken_o,
    input logic [W-1:0] target_o,
    input logic [W-1:0] link_o
);

    logic is_br;
    logic is_jmp;
    logic [W-1:0] fall;

    // Classify the present kind and the expected fall-through address.
    always_comb begin
        is_br  = (kind_i >= 4'd1) && (kind_i <= 4'd6);
        is_jmp = (kind_i == 4'd7) || (kind_i == 4'd8);
        fall   = pc_i + W'(4);
    end

    // Invariants relating the outputs to the operands.
    always_comb begin
        if (!is_br && !is_jmp) begin
            assert_idle_quiet_R1: assert (!taken_o && link_o == '0 && target_o == fall);
        end
        if (kind_i == 4'd1 && taken_o) begin
            assert_eq_taken_R2: assert (rs1_i == rs2_i);
        end
        if (kind_i == 4'd2 && taken_o) begin
            assert_ne_taken_R2: assert (rs1_i != rs2_i);
        end
        if (kind_i == 4'd5 && taken_o) begin
            assert_ltu_taken_R4: assert (rs1_i < rs2_i);
        end
        if (kind_i == 4'd3 && taken_o) begin
            assert_lt_taken_R3: assert ($signed(rs1_i) < $signed(rs2_i));
        end
        if (is_br && !taken_o) begin
            assert_fallthrough_R6: assert (target_o == fall && link_o == '0);
        end
        if (is_jmp) begin
            assert_jump_link_R7: assert (taken_o && link_o == fall);
        end
        if (kind_i == 4'd8) begin
            assert_regjump_even_R8: assert (target_o[0] == 1'b0);
        end
        if (kind_i == 4'd7) begin
            assert_jal_dest_R7: assert (target_o == pc_i + {imm_i[W-1:1], 1'b0});
        end
    end

endmodule

bind bru_unit bru_unit_chk #(.W(W)) u_chk (
    .kind_i   (kind_i),
    .rs1_i    (rs1_i),
    .rs2_i    (rs2_i),
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .taken_o  (taken_o),
    .target_o (target_o),
    .link_o   (link_o)
);

// File: tb/bru_unit_tb.sv
// bru_unit_tb: table-driven bench for the resolver, then directed cases.
module bru_unit_tb;

    logic        clk = 1'b0;
    logic [3:0]  kind_i = '0;
    logic [31:0] rs1_i = '0, rs2_i = '0, pc_i = '0, imm_i = '0;
    logic        taken_o;
    logic [31:0] target_o, link_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bru_unit u_dut (
        .kind_i   (kind_i),
        .rs1_i    (rs1_i),
        .rs2_i    (rs2_i),
        .pc_i     (pc_i),
        .imm_i    (imm_i),
        .taken_o  (taken_o),
        .target_o (target_o),
        .link_o   (link_o)
    );

    typedef struct packed {
        logic [3:0]  kind;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] pc;
        logic [31:0] imm;
        logic        exp_taken;
        logic [31:0] exp_target;
        logic [31:0] exp_link;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 32'h5, 32'h5, 32'h100, 32'h10, 1'b1, 32'h110, 32'h0},                    // R2
        '{4'd1, 32'h5, 32'h6, 32'h100, 32'h10, 1'b0, 32'h104, 32'h0},                    // R2
        '{4'd2, 32'h5, 32'h6, 32'h100, 32'hFFFFFFF0, 1'b1, 32'hF0, 32'h0},               // R2
        '{4'd2, 32'h7, 32'h7, 32'h100, 32'h10, 1'b0, 32'h104, 32'h0},                    // R2
        '{4'd3, 32'hFFFFFFFF, 32'h1, 32'h100, 32'h8, 1'b1, 32'h108, 32'h0},              // R3
        '{4'd5, 32'hFFFFFFFF, 32'h1, 32'h100, 32'h8, 1'b0, 32'h104, 32'h0},              // R4
        '{4'd4, 32'hFFFFFFFF, 32'h1, 32'h100, 32'h8, 1'b0, 32'h104, 32'h0},              // R3
        '{4'd6, 32'hFFFFFFFF, 32'h1, 32'h100, 32'h8, 1'b1, 32'h108, 32'h0},              // R4
        '{4'd4, 32'h3, 32'h3, 32'h100, 32'h20, 1'b1, 32'h120, 32'h0},                    // R3
        '{4'd3, 32'h3, 32'h3, 32'h100, 32'h20, 1'b0, 32'h104, 32'h0},                    // R3
        '{4'd6, 32'h0, 32'hFFFFFFFF, 32'h100, 32'h20, 1'b0, 32'h104, 32'h0},             // R4
        '{4'd5, 32'h0, 32'hFFFFFFFF, 32'h100, 32'h7FE, 1'b1, 32'h8FE, 32'h0},            // R4
        '{4'd7, 32'h0, 32'h0, 32'h100, 32'hFFFFF000, 1'b1, 32'hFFFFF100, 32'h104},       // R7
        '{4'd8, 32'h2001, 32'h0, 32'h100, 32'h4, 1'b1, 32'h2004, 32'h104},               // R8
        '{4'd8, 32'h3000, 32'h0, 32'h100, 32'hFFFFFFFF, 1'b1, 32'h2FFE, 32'h104},        // R8
        '{4'd0, 32'h9, 32'h9, 32'h100, 32'h40, 1'b0, 32'h104, 32'h0},                    // R1
        '{4'd12, 32'h9, 32'h9, 32'h100, 32'h40, 1'b0, 32'h104, 32'h0},                   // R1
        '{4'd1, 32'h5, 32'h5, 32'h100, 32'h11, 1'b1, 32'h110, 32'h0},                    // R6 odd imm
        '{4'd3, 32'h80000000, 32'h7FFFFFFF, 32'h100, 32'hC, 1'b1, 32'h10C, 32'h0},       // R3 extreme
        '{4'd7, 32'h0, 32'h0, 32'hFFFFFFFC, 32'h8, 1'b1, 32'h4, 32'h0}                   // R10 wrap
    };

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd1, 4'd2: return "R2";
            4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R4";
            4'd7:       return "R7";
            4'd8:       return "R8";
            default:    return "R1";
        endcase
    endfunction

    task automatic apply(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] pc, input logic [31:0] imm);
        @(negedge clk);
        kind_i = k; rs1_i = a; rs2_i = b; pc_i = pc; imm_i = imm;
        #2;
    endtask

    task automatic check(input string req, input logic et, input logic [31:0] etg,
                         input logic [31:0] el);
        total++;
        if (taken_o !== et || target_o !== etg || link_o !== el) begin
            bad++;
            $display("FAIL %s: got taken=%b target=%h link=%h exp taken=%b target=%h link=%h",
                     req, taken_o, target_o, link_o, et, etg, el);
        end
    endtask

    initial begin
        // Idle state with all-zero inputs (R1).
        #2;
        check("R1", 1'b0, 32'h4, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].kind, VECS[i].a, VECS[i].b, VECS[i].pc, VECS[i].imm);
            check(req_of(VECS[i].kind), VECS[i].exp_taken, VECS[i].exp_target, VECS[i].exp_link);
        end

        // R5: greater-or-equal kinds are exact inverses of less-than kinds.
        for (int j = 0; j < 6; j++) begin
            logic [31:0] a, b;
            logic t_lt, t_ltu;
            a = 32'h7FFFFFFF * j + 32'h80000000 * (j % 2);
            b = 32'h12345678 ^ (32'h1 << (j * 5));
            apply(4'd3, a, b, 32'h200, 32'h40); t_lt  = taken_o;
            apply(4'd4, a, b, 32'h200, 32'h40);
            check("R5", ~t_lt, t_lt ? 32'h204 : 32'h240, 32'h0);
            apply(4'd5, a, b, 32'h200, 32'h40); t_ltu = taken_o;
            apply(4'd6, a, b, 32'h200, 32'h40);
            check("R5", ~t_ltu, t_ltu ? 32'h204 : 32'h240, 32'h0);
        end

        // R9: same inputs after different history give same outputs.
        apply(4'd8, 32'hFFFFFFFF, 32'h0, 32'h500, 32'h0);
        check("R8", 1'b1, 32'hFFFFFFFE, 32'h504);
        apply(4'd2, 32'h1, 32'h1, 32'h500, 32'h40);
        check("R9", 1'b0, 32'h504, 32'h0);
        apply(4'd7, 32'h0, 32'h0, 32'h500, 32'h40);
        apply(4'd2, 32'h1, 32'h1, 32'h500, 32'h40);
        check("R9", 1'b0, 32'h504, 32'h0);

        // R10: register jump sum wraps; R6 taken branch near top of space.
        apply(4'd8, 32'hFFFFFFF0, 32'h0, 32'h0, 32'h21);
        check("R10", 1'b1, 32'h10, 32'h4);
        apply(4'd6, 32'h8, 32'h8, 32'hFFFFFFF8, 32'h10);
        check("R6", 1'b1, 32'h8, 32'h0);
        // R1 highest undefined code with a jump-like operand set.
        apply(4'd15, 32'h1, 32'h2, 32'h300, 32'h8);
        check("R1", 1'b0, 32'h304, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule